// File: doc/BRIEF.md
# Accumulator Processor with Memory-Linked Subroutines

This block is a small multicycle processor built around a single accumulator. It runs a fetch, decode and execute loop from a program counter over one memory that holds both code and data. Every instruction is one 16-bit word. The upper four bits choose the operation and the lower twelve bits are an operand: an immediate value, an absolute word address or a jump target.

Subroutines need neither a stack nor a link register. A call stores its return address in the first word of the subroutine and starts executing at the next word. The subroutine returns with an indirect jump through that word. A signed overflow on an add leaves the accumulator unchanged. Instead it latches the faulting opcode, both addends, the destination code and the faulting address, and it redirects execution to a fixed handler address. Any opcode that is not defined stops the processor.

The memory is outside the block. It is a synchronous single-port array: read data appears on the cycle after a read request, and a write takes effect on the clock edge.

Top module: `acc_cpu`

## Requirements
- R1: After reset the program counter and accumulator are 0, no trap is pending, and the block is neither halted nor flagged illegal. The first cycle out of reset requests a read of address 0. The opcode field is bits [15:12] and the operand field is bits [11:0].
- R2: Opcode 1 adds the operand, zero-extended to 16 bits, to the accumulator. Every instruction that does not change control flow advances the program counter by one.
- R3: Opcode 2 adds the memory word at the operand address to the accumulator. Opcode 3 loads that word into the accumulator. Opcode 4 stores the accumulator into that word.
- R4: Opcode 5 loads its operand into the program counter.
- R5: Opcode 6 loads its operand into the program counter only when the accumulator is zero. Otherwise the program counter advances by one.
- R6: Opcode 7 writes the address after the call, zero-extended, into the word at the operand address. It then sets the program counter to operand + 1.
- R7: Opcode 8 reads the word at the operand address and loads its low 12 bits into the program counter.
- R8: When an add (opcode 1 or 2) overflows as a signed 16-bit sum, the accumulator keeps its value and the program counter becomes 0x001. trap_active rises and latches the opcode, the accumulator value, the addend, the destination code 01 (accumulator) and the faulting instruction's address.
- R9: An overflow while a trap is already pending still leaves the accumulator unchanged and vectors to 0x001, but keeps the first latched context.
- R10: A one-cycle pulse on trap_clr drops trap_active on the following edge, unless an overflow traps on that same edge.
- R11: Opcodes 0 and 9 to 15 set illegal, halt the processor with the program counter on the offending word, and stop all memory traffic until reset.
- R12: Each instruction takes exactly three cycles (fetch, decode, execute) with at most one memory access per cycle. retire pulses for one cycle in the execute state of each completed instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_clr | input | 1 | Releases a pending trap |
| mem_addr | output | 12 | Memory word address |
| mem_rd_en | output | 1 | Read request; data returns on the next cycle |
| mem_wr_en | output | 1 | Write request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data from the previous read request |
| acc_out | output | 16 | Accumulator |
| pc_out | output | 12 | Program counter |
| retire | output | 1 | Pulses in the execute cycle of each instruction |
| halted | output | 1 | Processor stopped |
| illegal | output | 1 | An undefined opcode was decoded |
| trap_active | output | 1 | An overflow trap is pending |
| trap_opc | output | 4 | Opcode of the faulting add |
| trap_src_a | output | 16 | Accumulator value at the fault |
| trap_src_b | output | 16 | Addend at the fault |
| trap_dest | output | 2 | Destination code of the faulting add |
| trap_pc | output | 12 | Address of the faulting instruction |

## Verification
The hardest state to reach is a second overflow taken while the first trap is still pending. To get there, the handler must resume normal execution, rebuild an accumulator value next to the signed limit, overflow again, and then leave the trap loop. The stimulus does this with a handler that returns through an indirect jump whose pointer word the program rewrites. The first pass lands in code that stores a new pointer and overflows again. The second pass goes to a word holding an undefined opcode. Subroutine linkage is reached by calling the same subroutine twice from consecutive words, so the saved return word is overwritten and has to be read back correctly both times.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_ADDI = 4'd1;
  localparam logic [OPC_W-1:0] OPC_ADDM = 4'd2;
  localparam logic [OPC_W-1:0] OPC_LDM  = 4'd3;
  localparam logic [OPC_W-1:0] OPC_STM  = 4'd4;
  localparam logic [OPC_W-1:0] OPC_JMP  = 4'd5;
  localparam logic [OPC_W-1:0] OPC_BZ   = 4'd6;
  localparam logic [OPC_W-1:0] OPC_CALL = 4'd7;
  localparam logic [OPC_W-1:0] OPC_JI   = 4'd8;

  localparam logic [1:0] DEST_NONE = 2'b00;
  localparam logic [1:0] DEST_ACC  = 2'b01;

  typedef enum logic [1:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_HALT} state_e;

  typedef struct packed {
    logic add;   // accumulator add
    logic imm;   // addend is the operand field
    logic rd;    // operand access reads memory
    logic wr;    // operand access writes memory
    logic ld;    // accumulator takes memory word
    logic jmp;
    logic bz;
    logic call;
    logic ji;
    logic bad;   // undefined opcode
  } ctrl_t;

  // Signed overflow of a two's complement sum, from the three sign bits
  function automatic logic signed_ovf(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl = '0;
    case (opc)
      OPC_ADDI: begin ctrl.add = 1'b1; ctrl.imm = 1'b1; end
      OPC_ADDM: begin ctrl.add = 1'b1; ctrl.rd  = 1'b1; end
      OPC_LDM:  begin ctrl.ld  = 1'b1; ctrl.rd  = 1'b1; end
      OPC_STM:  ctrl.wr = 1'b1;
      OPC_JMP:  ctrl.jmp = 1'b1;
      OPC_BZ:   ctrl.bz = 1'b1;
      OPC_CALL: begin ctrl.call = 1'b1; ctrl.wr = 1'b1; end
      OPC_JI:   begin ctrl.ji = 1'b1; ctrl.rd = 1'b1; end
      default:  ctrl.bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         ovf
);

  assign sum = a + b;
  assign ovf = signed_ovf(a[W-1], b[W-1], sum[W-1]);

endmodule

// File: rtl/acc_cpu_trap.sv
module acc_cpu_trap
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              clr,
  input  logic [OPC_W-1:0]  f_opc,
  input  logic [DATA_W-1:0] f_a,
  input  logic [DATA_W-1:0] f_b,
  input  logic [ADDR_W-1:0] f_pc,
  output logic              active,
  output logic [OPC_W-1:0]  t_opc,
  output logic [DATA_W-1:0] t_a,
  output logic [DATA_W-1:0] t_b,
  output logic [1:0]        t_dest,
  output logic [ADDR_W-1:0] t_pc
);

  logic capture;
  assign capture = fire && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      t_opc  <= '0;
      t_a    <= '0;
      t_b    <= '0;
      t_dest <= DEST_NONE;
      t_pc   <= '0;
    end else begin
      if (capture) begin
        t_opc  <= f_opc;
        t_a    <= f_a;
        t_b    <= f_b;
        t_dest <= DEST_ACC;
        t_pc   <= f_pc;
      end
      if (fire)     active <= 1'b1;
      else if (clr) active <= 1'b0;
    end
  end

  AST_TRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> active);  // R8
  AST_CONTEXT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && active) |=> ($stable(t_pc) && $stable(t_a) && $stable(t_b) && $stable(t_opc)));  // R9
  AST_CLR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fire) |=> !active);  // R10

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int unsigned TRAP_VEC = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      trap_clr,
  output logic [DATA_W-OPC_W-1:0]   mem_addr,
  output logic                      mem_rd_en,
  output logic                      mem_wr_en,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic [DATA_W-1:0]         acc_out,
  output logic [DATA_W-OPC_W-1:0]   pc_out,
  output logic                      retire,
  output logic                      halted,
  output logic                      illegal,
  output logic                      trap_active,
  output logic [OPC_W-1:0]          trap_opc,
  output logic [DATA_W-1:0]         trap_src_a,
  output logic [DATA_W-1:0]         trap_src_b,
  output logic [1:0]                trap_dest,
  output logic [DATA_W-OPC_W-1:0]   trap_pc
);

  localparam int ADDR_W = DATA_W - OPC_W;
  localparam logic [ADDR_W-1:0] VEC = ADDR_W'(TRAP_VEC);

  state_e             st_q;
  logic [ADDR_W-1:0]  pc_q, pc_inc, pc_nxt, opnd;
  logic [DATA_W-1:0]  acc_q, ir_q, add_b, sum;
  ctrl_t              dec_c, ctrl_q;
  logic               ovf, bad_q;

  // Named events for checking
  logic ex, ex_add, ex_ovf, ex_call, ex_ctl, ex_seq, acc_zero;

  acc_cpu_decode u_dec (
    .opc  (mem_rdata[DATA_W-1 -: OPC_W]),
    .ctrl (dec_c)
  );

  assign pc_inc   = pc_q + ADDR_W'(1);
  assign opnd     = ir_q[ADDR_W-1:0];
  assign add_b    = ctrl_q.imm ? DATA_W'(opnd) : mem_rdata;
  assign acc_zero = (acc_q == '0);

  acc_cpu_alu #(.W(DATA_W)) u_alu (
    .a   (acc_q),
    .b   (add_b),
    .sum (sum),
    .ovf (ovf)
  );

  assign ex      = (st_q == ST_EXEC);
  assign ex_add  = ex && ctrl_q.add;
  assign ex_ovf  = ex_add && ovf;
  assign ex_call = ex && ctrl_q.call;
  assign ex_ctl  = ex && (ctrl_q.jmp || ctrl_q.bz || ctrl_q.call || ctrl_q.ji);
  assign ex_seq  = ex && !ex_ctl && !ex_ovf;

  // One memory access per state: instruction read in fetch, operand access in decode
  always_comb begin
    mem_addr  = pc_q;
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    mem_wdata = acc_q;
    case (st_q)
      ST_FETCH: mem_rd_en = 1'b1;
      ST_DECODE: begin
        mem_addr  = mem_rdata[ADDR_W-1:0];
        mem_rd_en = dec_c.rd;
        mem_wr_en = dec_c.wr;
        mem_wdata = dec_c.call ? DATA_W'(pc_inc) : acc_q;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (ex_ovf)            pc_nxt = VEC;
    else if (ctrl_q.jmp)   pc_nxt = opnd;
    else if (ctrl_q.bz)    pc_nxt = acc_zero ? opnd : pc_inc;
    else if (ctrl_q.call)  pc_nxt = opnd + ADDR_W'(1);
    else if (ctrl_q.ji)    pc_nxt = mem_rdata[ADDR_W-1:0];
    else                   pc_nxt = pc_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FETCH;
      pc_q   <= '0;
      acc_q  <= '0;
      ir_q   <= '0;
      ctrl_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_FETCH: st_q <= ST_DECODE;
        ST_DECODE: begin
          ir_q   <= mem_rdata;
          ctrl_q <= dec_c;
          if (dec_c.bad) begin
            st_q  <= ST_HALT;
            bad_q <= 1'b1;
          end else begin
            st_q <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          pc_q <= pc_nxt;
          if (ctrl_q.add && !ovf) acc_q <= sum;
          else if (ctrl_q.ld)     acc_q <= mem_rdata;
          st_q <= ST_FETCH;
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

  acc_cpu_trap #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_trap (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (ex_ovf),
    .clr    (trap_clr),
    .f_opc  (ir_q[DATA_W-1 -: OPC_W]),
    .f_a    (acc_q),
    .f_b    (add_b),
    .f_pc   (pc_q),
    .active (trap_active),
    .t_opc  (trap_opc),
    .t_a    (trap_src_a),
    .t_b    (trap_src_b),
    .t_dest (trap_dest),
    .t_pc   (trap_pc)
  );

  assign acc_out = acc_q;
  assign pc_out  = pc_q;
  assign retire  = ex;
  assign halted  = (st_q == ST_HALT);
  assign illegal = bad_q;

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_q.rd, ctrl_q.wr, ctrl_q.bad};

  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));  // R12
  AST_RETIRE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (!retire && mem_rd_en && mem_addr == pc_q));  // R12
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ex_seq |=> (pc_q == $past(pc_inc)));  // R2
  AST_BZ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (ex && ctrl_q.bz && !acc_zero) |=> (pc_q == $past(pc_inc)));  // R5
  AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    ex_call |-> ($past(mem_wr_en) && $past(mem_wdata) == DATA_W'(pc_inc)));  // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf |=> ($stable(acc_q) && pc_q == VEC));  // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && illegal && !mem_rd_en && !mem_wr_en));  // R11

endmodule

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_clr = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [15:0] acc_out;
  logic [11:0] pc_out;
  logic        retire, halted, illegal, trap_active;
  logic [3:0]  trap_opc;
  logic [15:0] trap_src_a, trap_src_b;
  logic [1:0]  trap_dest;
  logic [11:0] trap_pc;

  always #2.5 clk = ~clk;

  acc_cpu u0 (
    .clk(clk), .rst_n(rst_n), .trap_clr(trap_clr),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .acc_out(acc_out), .pc_out(pc_out), .retire(retire),
    .halted(halted), .illegal(illegal), .trap_active(trap_active),
    .trap_opc(trap_opc), .trap_src_a(trap_src_a), .trap_src_b(trap_src_b),
    .trap_dest(trap_dest), .trap_pc(trap_pc)
  );

  // Synchronous memory shared by code and data
  logic [15:0] mem [4096];
  logic [15:0] mdl [4096];

  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_ret = -1;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [11:0] pc;
    logic [15:0] acc;
    logic        ta;
    int          req;
  } exp_t;
  exp_t exp_q[$];

  // Model end state
  logic [11:0] m_pc;
  logic [15:0] m_acc;
  logic        m_tact;
  logic [11:0] m_tpc;
  logic [3:0]  m_topc;
  logic [15:0] m_ta, m_tb;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Instruction-level model that produces the expected state after each instruction
  task automatic run_model();
    logic [11:0] p;
    logic [15:0] a, w, b, s;
    logic [3:0]  op;
    logic [11:0] x;
    bit ta, done;
    int rq;
    exp_t e;
    p = '0; a = '0; ta = 0; done = 0;
    m_tpc = '0; m_topc = '0; m_ta = '0; m_tb = '0;
    for (int n = 0; n < 2000 && !done; n++) begin
      w = mdl[p]; op = w[15:12]; x = w[11:0]; rq = 0;
      case (op)
        4'd1, 4'd2: begin
          b = (op == 4'd1) ? {4'h0, x} : mdl[x];
          s = a + b;
          if (a[15] == b[15] && s[15] != a[15]) begin
            if (!ta) begin
              ta = 1; m_tpc = p; m_topc = op; m_ta = a; m_tb = b;
              rq = 8;
            end else begin
              rq = 9;
            end
            p = 12'h001;
          end else begin
            a = s; p = p + 12'd1;
            rq = (op == 4'd1) ? 2 : 3;
          end
        end
        4'd3: begin a = mdl[x]; p = p + 12'd1; rq = 3; end
        4'd4: begin mdl[x] = a; p = p + 12'd1; rq = 3; end
        4'd5: begin p = x; rq = 4; end
        4'd6: begin p = (a == 16'h0) ? x : p + 12'd1; rq = 5; end
        4'd7: begin mdl[x] = {4'h0, p + 12'd1}; p = x + 12'd1; rq = 6; end
        4'd8: begin p = mdl[x][11:0]; rq = 7; end
        default: done = 1;
      endcase
      if (!done) begin
        e.pc = p; e.acc = a; e.ta = ta; e.req = rq;
        exp_q.push_back(e);
      end
    end
    m_pc = p; m_acc = a; m_tact = ta;
  endtask

  // Monitor: compares each retired instruction against the scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && retire) begin
        if (last_ret >= 0)
          chk((cyc - last_ret) == 3, "R12", "cycles per instruction", cyc - last_ret, 3);
        last_ret = cyc;
        @(negedge clk);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R12", "retire with empty scoreboard", int'(pc_out), 0);
        end else begin
          e = exp_q.pop_front();
          chk(pc_out == e.pc && acc_out == e.acc && trap_active == e.ta,
              $sformatf("R%0d", e.req), "pc/acc/trap after instruction",
              {pc_out, acc_out, 3'b0, trap_active},
              {e.pc, e.acc, 3'b0, e.ta});
        end
      end
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
  endtask

  task automatic run_prog(input string trap_req);
    int errs;
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4096; i++) mdl[i] = mem[i];
    exp_q.delete();
    run_model();
    last_ret = -1;
    @(negedge clk);
    chk(pc_out == 12'h0 && acc_out == 16'h0 && !trap_active && !halted && !illegal,
        "R1", "reset state", {pc_out, acc_out, trap_active, halted, illegal}, 0);
    rst_n = 1'b1;
    #1;
    chk(mem_rd_en && !mem_wr_en && mem_addr == 12'h0, "R1", "first fetch address",
        int'(mem_addr), 0);
    for (int c = 0; c < 3000 && !halted; c++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(halted && illegal, "R11", "halt on undefined opcode", {halted, illegal}, 3);
    chk(pc_out == m_pc, "R11", "pc at undefined opcode", int'(pc_out), int'(m_pc));
    chk(acc_out == m_acc, "R2", "final accumulator", int'(acc_out), int'(m_acc));
    chk(exp_q.size() == 0, "R12", "instructions left unretired", exp_q.size(), 0);
    chk(trap_active == m_tact, "R8", "trap pending", int'(trap_active), int'(m_tact));
    if (m_tact) begin
      chk(trap_pc == m_tpc, trap_req, "trap address", int'(trap_pc), int'(m_tpc));
      chk(trap_opc == m_topc, trap_req, "trap opcode", int'(trap_opc), int'(m_topc));
      chk(trap_src_a == m_ta, trap_req, "trap accumulator", int'(trap_src_a), int'(m_ta));
      chk(trap_src_b == m_tb, trap_req, "trap addend", int'(trap_src_b), int'(m_tb));
      chk(trap_dest == 2'b01, "R8", "trap destination", int'(trap_dest), 1);
    end
    errs = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== mdl[i]) errs++;
    chk(errs == 0, "R3", "memory image (stores and call links)", errs, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R12 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // Program 1: immediate and memory arithmetic, loads, stores; ends on opcode 9
    clear_mem();
    mem[12'h000] = 16'h1005;   // ADDI 5
    mem[12'h001] = 16'h1FFF;   // ADDI 0xFFF (zero-extended) R2
    mem[12'h002] = 16'h4100;   // STM 0x100
    mem[12'h003] = 16'h2100;   // ADDM 0x100
    mem[12'h004] = 16'h3101;   // LDM 0x101
    mem[12'h005] = 16'h2102;   // ADDM 0x102
    mem[12'h006] = 16'h9000;   // undefined R11
    mem[12'h101] = 16'h1234;
    mem[12'h102] = 16'h0001;
    run_prog("R8");
    chk(mem[12'h100] == 16'h1004, "R3", "stored accumulator", int'(mem[12'h100]), 16'h1004);

    // Program 2: jump, branch both ways, repeated call and indirect return; ends on opcode 15
    clear_mem();
    mem[12'h000] = 16'h5010;   // JMP 0x10 R4
    mem[12'h010] = 16'h6020;   // BZ taken (acc 0) R5
    mem[12'h020] = 16'h1003;
    mem[12'h021] = 16'h6030;   // BZ not taken R5
    mem[12'h022] = 16'h7040;   // CALL 0x40 R6
    mem[12'h023] = 16'h7040;   // CALL 0x40 again
    mem[12'h024] = 16'hF000;
    mem[12'h030] = 16'hF001;   // reached only on a wrong branch
    mem[12'h041] = 16'h1001;
    mem[12'h042] = 16'h8040;   // JI 0x40 return R7
    run_prog("R8");
    chk(mem[12'h040] == 16'h0024, "R6", "saved return word", int'(mem[12'h040]), 16'h0024);

    // Program 3: positive overflow on an immediate add; handler word is opcode 0
    clear_mem();
    mem[12'h000] = 16'h5010;
    mem[12'h001] = 16'h0123;   // trap vector, undefined
    mem[12'h010] = 16'h3080;   // LDM 0x80 -> 0x7FF0
    mem[12'h011] = 16'h100F;   // -> 0x7FFF
    mem[12'h012] = 16'h1001;   // overflow R8
    mem[12'h080] = 16'h7FF0;
    run_prog("R8");

    // Program 4: negative overflow on a memory add, then a second overflow while pending
    clear_mem();
    mem[12'h000] = 16'h5010;
    mem[12'h001] = 16'h8050;   // handler: JI through 0x50
    mem[12'h010] = 16'h3060;   // LDM 0x60 -> 0x8000
    mem[12'h011] = 16'h2061;   // ADDM 0xFFFF overflow R8
    mem[12'h030] = 16'h3051;
    mem[12'h031] = 16'h4050;   // redirect handler pointer
    mem[12'h032] = 16'h3052;   // -> 0x7FFF
    mem[12'h033] = 16'h1002;   // overflow again while pending R9
    mem[12'h040] = 16'hA000;
    mem[12'h050] = 16'h0030;
    mem[12'h051] = 16'h0040;
    mem[12'h052] = 16'h7FFF;
    mem[12'h060] = 16'h8000;
    mem[12'h061] = 16'hFFFF;
    run_prog("R9");

    // Trap release R10
    chk(trap_active, "R10", "pending before release", int'(trap_active), 1);
    trap_clr = 1'b1;
    @(negedge clk);
    trap_clr = 1'b0;
    chk(!trap_active, "R10", "released by trap_clr", int'(trap_active), 0);
    @(negedge clk);
    chk(!trap_active && halted, "R10", "stays released", {trap_active, halted}, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule